// File: doc/BRIEF.md
# Radix-2 FFT Stage Address Sequencer

This block walks an in-place radix-2 transform over an N-point array that sits in data memory. After a start pulse it runs through log2(N) stages. In each stage it issues N/2 butterflies. For every butterfly it presents two operand addresses for a read. The two addresses are a power-of-two span apart, and that span is halved on each new stage. The same address pair is presented for the write-back one cycle later. On the final stage, the write-back goes to the bit-reversed locations, so the spectrum ends up in natural order.

Each read also carries the stage number and a twiddle exponent for an external coefficient table. A ready input throttles the sequence: while it is low, no read is issued and the position in the sequence holds. The arithmetic and the coefficient values are handled elsewhere. The transform size is given as its base-2 logarithm and is captured when the start pulse is accepted.

Top module: `fftAddrSeq`

## Requirements
- R1: After reset, busy, done, rdValid and wrEn are all low.
- R2: A run of size L = log2(N) issues exactly L stages of N/2 reads each. stageIdx counts 0 to L-1 in order.
- R3: In stage s the span is h = N >> (s+1). Each read satisfies rdAddrB = rdAddrA + h, and bit log2(h) of rdAddrA is clear. In stage 0 the pair is k and k+N/2.
- R4: Within a stage, butterfly index b splits into group g = b / h and offset o = b mod h. The read is issued at rdAddrA = 2·h·g + o. Reads proceed in increasing b, so every address is read exactly once per stage.
- R5: Every read is followed in the next cycle by wrEn high. On stages before the last, the write addresses equal the read addresses of that pair.
- R6: On the final stage, wrAddrA and wrAddrB are the read addresses of the pair with their low L bits reversed.
- R7: While ready is low during a run, rdValid stays low and the sequence position holds. The next read is the same pair that was pending.
- R8: twIdx equals o << s for the butterfly being read.
- R9: done is high for exactly one cycle, which is the cycle after the last write. busy is high from the cycle after start is accepted through the done cycle, and it is low afterwards.
- R10: start is ignored while busy. The run completes with its original size, and no restart follows.
- R11: The size input holds log2(N). A value of 0 is treated as 1, and a value above MAX_LOG2N is treated as MAX_LOG2N.
- R12: lastStage is high with every read of the final stage and low with every earlier read. On the final stage the span is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| log2N | input | LOG_W | Base-2 logarithm of the transform size |
| ready | input | 1 | Allow a butterfly read this cycle |
| rdValid | output | 1 | A read pair is issued this cycle |
| rdAddrA | output | ADDR_W | Lower operand address |
| rdAddrB | output | ADDR_W | Upper operand address |
| stageIdx | output | LOG_W | Stage of the current read |
| twIdx | output | ADDR_W | Twiddle exponent of the current read |
| lastStage | output | 1 | Current read belongs to the final stage |
| wrEn | output | 1 | Write-back of the previous cycle's pair |
| wrAddrA | output | ADDR_W | Write address for the lower result |
| wrAddrB | output | ADDR_W | Write address for the upper result |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
A butterfly read and the write-back of the previous pair usually share a cycle. At a stage boundary, the first read of the next stage coincides with the write of the last pair of the old stage. When entering the final stage, that write is still in natural order while the simultaneous read is already flagged as final. Full-rate runs provoke these overlaps. Irregular ready patterns split them apart. In every cycle the bench compares both the read pair and the write pair against its own stage, group and offset model, with bit reversal applied only to pairs read in the final stage.

// File: rtl/fftSeqPkg.sv
package fftSeqPkg;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_RUN,
    SEQ_FLUSH,
    SEQ_FIN
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture size, clear counters
    logic issue;  // a butterfly read goes out this cycle
  } seqCtl_t;

endpackage

// File: rtl/fftSeqCtrl.sv
module fftSeqCtrl
  import fftSeqPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    ready,
  input  logic    lastBfly,
  input  logic    lastStg,
  output seqCtl_t ctl,
  output logic    rdValid,
  output logic    busy,
  output logic    done,
  output logic    lastStage
);

  seqState_t stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= SEQ_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    ctl    = '0;
    unique case (stateQ)
      SEQ_IDLE: begin
        if (start) begin
          ctl.load = 1'b1;
          stateD   = SEQ_RUN;
        end
      end
      SEQ_RUN: begin
        if (ready) begin
          ctl.issue = 1'b1;
          if (lastBfly && lastStg) stateD = SEQ_FLUSH;
        end
      end
      SEQ_FLUSH: stateD = SEQ_FIN;
      SEQ_FIN:   stateD = SEQ_IDLE;
      default:   stateD = SEQ_IDLE;
    endcase
  end

  assign rdValid   = ctl.issue;
  assign busy      = (stateQ != SEQ_IDLE);
  assign done      = (stateQ == SEQ_FIN);
  assign lastStage = (stateQ == SEQ_RUN) && lastStg;

  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !ctl.load);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

endmodule

// File: rtl/fftSeqPath.sv
module fftSeqPath
  import fftSeqPkg::*;
#(
  parameter int MAX_LOG2N = 5,
  parameter int ADDR_W    = MAX_LOG2N,
  parameter int LOG_W     = $clog2(MAX_LOG2N + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [LOG_W-1:0]  log2N,
  output logic              lastBfly,
  output logic              lastStg,
  output logic [ADDR_W-1:0] rdAddrA,
  output logic [ADDR_W-1:0] rdAddrB,
  output logic [LOG_W-1:0]  stageIdx,
  output logic [ADDR_W-1:0] twIdx,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddrA,
  output logic [ADDR_W-1:0] wrAddrB
);

  logic [LOG_W-1:0]  sizeQ, sizeD, stageQ, logSpan;
  logic [ADDR_W-1:0] bflyQ, halfLast, spanMask, offset, group;
  logic [ADDR_W-1:0] baseAddr, partnerAddr, revFullA, revFullB, revA, revB;
  logic              wrEnQ;
  logic [ADDR_W-1:0] wrAQ, wrBQ;

  // size capture with clamping to the legal range
  always_comb begin
    if (log2N == '0)
      sizeD = LOG_W'(1);
    else if (log2N > LOG_W'(MAX_LOG2N))
      sizeD = LOG_W'(MAX_LOG2N);
    else
      sizeD = log2N;
  end

  // position decode: group-major, offset inner
  assign halfLast    = (ADDR_W'(1) << (sizeQ - LOG_W'(1))) - ADDR_W'(1);
  assign lastBfly    = (bflyQ == halfLast);
  assign lastStg     = (stageQ == sizeQ - LOG_W'(1));
  assign logSpan     = sizeQ - LOG_W'(1) - stageQ;
  assign spanMask    = (ADDR_W'(1) << logSpan) - ADDR_W'(1);
  assign offset      = bflyQ & spanMask;
  assign group       = bflyQ >> logSpan;
  assign baseAddr    = (group << (logSpan + LOG_W'(1))) | offset;
  assign partnerAddr = baseAddr | (ADDR_W'(1) << logSpan);

  // bit reversal over the active width: mirror all bits then shift down
  for (genvar i = 0; i < ADDR_W; i++) begin : g_rev
    assign revFullA[i] = baseAddr[ADDR_W-1-i];
    assign revFullB[i] = partnerAddr[ADDR_W-1-i];
  end
  assign revA = revFullA >> (LOG_W'(ADDR_W) - sizeQ);
  assign revB = revFullB >> (LOG_W'(ADDR_W) - sizeQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sizeQ  <= LOG_W'(1);
      stageQ <= '0;
      bflyQ  <= '0;
    end else if (ctl.load) begin
      sizeQ  <= sizeD;
      stageQ <= '0;
      bflyQ  <= '0;
    end else if (ctl.issue) begin
      if (lastBfly) begin
        bflyQ  <= '0;
        stageQ <= stageQ + LOG_W'(1);
      end else begin
        bflyQ  <= bflyQ + ADDR_W'(1);
      end
    end
  end

  // write-back stage, one cycle behind the read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrEnQ <= 1'b0;
      wrAQ  <= '0;
      wrBQ  <= '0;
    end else begin
      wrEnQ <= ctl.issue;
      if (ctl.issue) begin
        wrAQ <= lastStg ? revA : baseAddr;
        wrBQ <= lastStg ? revB : partnerAddr;
      end
    end
  end

  assign rdAddrA  = baseAddr;
  assign rdAddrB  = partnerAddr;
  assign stageIdx = stageQ;
  assign twIdx    = offset << stageQ;
  assign wrEn     = wrEnQ;
  assign wrAddrA  = wrAQ;
  assign wrAddrB  = wrBQ;

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.issue && !ctl.load) |=> ($stable(bflyQ) && $stable(stageQ)));

  // R2
  stage_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.issue |-> (stageQ < sizeQ && bflyQ <= halfLast));

endmodule

// File: rtl/fftAddrSeq.sv
module fftAddrSeq
  import fftSeqPkg::*;
#(
  parameter int MAX_LOG2N = 5,
  parameter int ADDR_W    = MAX_LOG2N,
  parameter int LOG_W     = $clog2(MAX_LOG2N + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LOG_W-1:0]  log2N,
  input  logic              ready,
  output logic              rdValid,
  output logic [ADDR_W-1:0] rdAddrA,
  output logic [ADDR_W-1:0] rdAddrB,
  output logic [LOG_W-1:0]  stageIdx,
  output logic [ADDR_W-1:0] twIdx,
  output logic              lastStage,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddrA,
  output logic [ADDR_W-1:0] wrAddrB,
  output logic              busy,
  output logic              done
);

  seqCtl_t ctl;
  logic    lastBfly, lastStg;

  fftSeqCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .ready     (ready),
    .lastBfly  (lastBfly),
    .lastStg   (lastStg),
    .ctl       (ctl),
    .rdValid   (rdValid),
    .busy      (busy),
    .done      (done),
    .lastStage (lastStage)
  );

  fftSeqPath #(
    .MAX_LOG2N (MAX_LOG2N),
    .ADDR_W    (ADDR_W),
    .LOG_W     (LOG_W)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .log2N    (log2N),
    .lastBfly (lastBfly),
    .lastStg  (lastStg),
    .rdAddrA  (rdAddrA),
    .rdAddrB  (rdAddrB),
    .stageIdx (stageIdx),
    .twIdx    (twIdx),
    .wrEn     (wrEn),
    .wrAddrA  (wrAddrA),
    .wrAddrB  (wrAddrB)
  );

  // R3
  pair_span_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (rdAddrA < rdAddrB && $countones(rdAddrA ^ rdAddrB) == 1));

  // R5
  writeback_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !lastStage) |=>
      (wrEn && wrAddrA == $past(rdAddrA) && wrAddrB == $past(rdAddrB)));

  // R9
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(wrEn) && !wrEn && !rdValid));

  // R12
  final_span_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && lastStage) |-> (rdAddrB == rdAddrA + ADDR_W'(1)));

  // R8
  first_twiddle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && stageIdx == '0) |-> (twIdx == rdAddrA));

endmodule

// File: tb/fftAddrSeq_bench.sv
module fftAddrSeq_bench;

  localparam int PERIOD    = 10;
  localparam int MAX_LOG2N = 5;
  localparam int ADDR_W    = MAX_LOG2N;
  localparam int LOG_W     = $clog2(MAX_LOG2N + 1);

  logic              clk = 1'b0;
  logic              rstN;
  logic              start;
  logic [LOG_W-1:0]  log2N;
  logic              ready;
  logic              rdValid, lastStage, wrEn, busy, done;
  logic [ADDR_W-1:0] rdAddrA, rdAddrB, twIdx, wrAddrA, wrAddrB;
  logic [LOG_W-1:0]  stageIdx;

  int checks = 0;
  int fails  = 0;

  always #(PERIOD / 2) clk = ~clk;

  fftAddrSeq #(.MAX_LOG2N(MAX_LOG2N)) u_fftAddrSeq (
    .clk(clk), .rstN(rstN), .start(start), .log2N(log2N), .ready(ready),
    .rdValid(rdValid), .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .stageIdx(stageIdx), .twIdx(twIdx), .lastStage(lastStage),
    .wrEn(wrEn), .wrAddrA(wrAddrA), .wrAddrB(wrAddrB),
    .busy(busy), .done(done)
  );

  task automatic chkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int brev(input int v, input int w);
    int r = 0;
    for (int i = 0; i < w; i++)
      if (((v >> i) & 1) != 0) r |= 1 << (w - 1 - i);
    return r;
  endfunction

  function automatic bit readyPat(input int mode, input int cyc);
    case (mode)
      1:       return (cyc % 3) != 1;
      2:       return (cyc % 5) >= 2;
      default: return 1'b1;
    endcase
  endfunction

  // one full run: drive, model and compare every cycle; returns reads seen
  task automatic runSeq(input int lgIn, input int eff, input int mode,
                        input bit poke, output int seen);
    int n = 1 << eff;
    int total = (n / 2) * eff;
    int reads = 0, s = 0, b = 0, cyc = 0;
    bit pend = 1'b0, pLast = 1'b0;
    int pA = 0, pB = 0;
    seen = 0;
    @(negedge clk);
    log2N = LOG_W'(lgIn);
    start = 1'b1;
    ready = 1'b0;
    while (reads < total || pend) begin
      bit rdy, expRd;
      @(negedge clk);
      start = poke;
      if (poke) log2N = LOG_W'(lgIn == 2 ? 3 : 2);
      rdy   = readyPat(mode, cyc);
      ready = rdy;
      #1;
      expRd = (reads < total) && rdy;
      chkEq(rdy ? "R2 rdValid" : "R7 rdValid under stall", int'(rdValid), int'(expRd));
      chkEq("R9 busy during run", int'(busy), 1);
      chkEq("R5 wrEn", int'(wrEn), int'(pend));
      if (rdValid) seen++;
      if (pend) begin
        chkEq(pLast ? "R6 wrAddrA" : "R5 wrAddrA", int'(wrAddrA), pLast ? brev(pA, eff) : pA);
        chkEq(pLast ? "R6 wrAddrB" : "R5 wrAddrB", int'(wrAddrB), pLast ? brev(pB, eff) : pB);
      end
      if (expRd) begin
        int h = n >> (s + 1);
        int o = b % h;
        int g = b / h;
        int k = g * 2 * h + o;
        chkEq("R4 rdAddrA", int'(rdAddrA), k);
        chkEq("R3 rdAddrB", int'(rdAddrB), k + h);
        chkEq("R2 stageIdx", int'(stageIdx), s);
        chkEq("R8 twIdx", int'(twIdx), o << s);
        chkEq("R12 lastStage", int'(lastStage), int'(s == eff - 1));
        pend = 1'b1; pA = k; pB = k + h; pLast = (s == eff - 1);
        reads++;
        b++;
        if (b == n / 2) begin b = 0; s++; end
      end else begin
        pend = 1'b0;
      end
      cyc++;
      if (cyc > 5000) begin
        chkEq("R9 run did not finish", cyc, total);
        break;
      end
    end
    @(negedge clk);
    #1;
    chkEq("R9 done pulse", int'(done), 1);
    chkEq("R9 busy at done", int'(busy), 1);
    chkEq("R9 no read at done", int'(rdValid), 0);
    chkEq("R9 no write at done", int'(wrEn), 0);
    @(negedge clk);
    start = 1'b0;
    #1;
    chkEq("R9 done width", int'(done), 0);
    chkEq("R9 idle after done", int'(busy), 0);
  endtask

  task automatic testReset();
    #1;
    chkEq("R1 busy", int'(busy), 0);
    chkEq("R1 done", int'(done), 0);
    chkEq("R1 rdValid", int'(rdValid), 0);
    chkEq("R1 wrEn", int'(wrEn), 0);
  endtask

  task automatic testEightFull();
    int seen;
    runSeq(3, 3, 0, 1'b0, seen);
    chkEq("R2 reads 8-point", seen, 12);
  endtask

  task automatic testStalls();
    int seen;
    runSeq(5, 5, 1, 1'b0, seen);
    chkEq("R7 reads 32-point stalled", seen, 80);
  endtask

  task automatic testTwoPoint();
    int seen;
    runSeq(1, 1, 2, 1'b0, seen);
    chkEq("R6 reads 2-point", seen, 1);
  endtask

  task automatic testStartBusy();
    int seen;
    runSeq(4, 4, 0, 1'b1, seen);
    chkEq("R10 reads with start held", seen, 32);
  endtask

  task automatic testClamp();
    int seen;
    runSeq(0, 1, 0, 1'b0, seen);
    chkEq("R11 size 0 as 1", seen, 1);
    runSeq(7, 5, 2, 1'b0, seen);
    chkEq("R11 size 7 as max", seen, 80);
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL R9 watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rstN  = 1'b0;
    start = 1'b0;
    ready = 1'b1;
    log2N = '0;
    repeat (3) @(posedge clk);
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    testEightFull();
    testStalls();
    testTwoPoint();
    testStartBusy();
    testClamp();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule